// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the register front end of an eight-line priority interrupt controller. It takes single-cycle byte writes and reads on a two-location bus, selected by `addr`. It steps through the setup word sequence, decodes the run-time command words and serves reads. The priority resolver sits beside it. The resolver's request and in-service registers and its current poll winner come back in as inputs. The sequencer drives the resolver's configuration: mask, vector base, priority base, mode flags and trigger-mode bits. It also issues one-cycle strobes that clear in-service lines, acknowledge a polled line and clear the resolver at setup.

Writes to location 0 carry either a setup start word or a command word. Writes to location 1 carry either the next setup word or, once setup is done, a new mask. The setup walk takes one, two or three further words, depending on two flags captured from the start word. A separate one-byte port loads the trigger-mode register. Only the bits allowed by a fixed writable mask take effect there.

Top module: `pic_cmd_seq`

## Requirements
- R1: After reset, `mask`, `vec_base`, `base`, `trig_mode`, `rdata`, every mode flag and every strobe are zero, and the sequencer is in the run state.
- R2: A write to address 0 with bit 4 set starts setup. One cycle later `init_clr` pulses for one cycle. `mask`, `vec_base`, `base`, auto-EOI, nested mode, rotate-on-auto-EOI, special mask, read select and the pending poll are cleared. Bit 1 is captured as `single_mode` and bit 0 as the mode-word-needed flag.
- R3: After the start word, writes to address 1 are taken as setup words and do not load `mask`. The number taken is 1 for single without mode word, 2 for single with mode word, 2 for cascaded without mode word, and 3 for cascaded with mode word. The next address-1 write loads `mask`.
- R4: The first setup word after the start word stores its bits 7:3 in `vec_base`.
- R5: The mode word, when expected, sets `nested_mode` from bit 4 and `auto_eoi` from bit 1.
- R6: A write to address 0 with bit 4 clear and bit 3 set is an option word. Bit 2 arms a poll. Bit 1 set loads the read select from bit 0 (1 = in-service, 0 = request). Bit 6 set loads `special_mask` from bit 5. A cleared enable bit leaves the matching setting unchanged.
- R7: Any other address-0 write is a command with code in bits 7:5. Codes 0 and 4 set `rot_on_aeoi` to 0 and 1 respectively.
- R8: Code 1 pulses `isr_clr` for the first set `isr` line found searching upward from `base`, wrapping modulo 8. Code 5 does the same and also sets `base` to that line + 1 mod 8. With `isr` zero, neither pulses nor changes `base`.
- R9: Code 3 pulses `isr_clr` for line bits 2:0. Code 7 does the same and sets `base` to line + 1 mod 8. Code 6 sets `base` to bits 2:0 + 1 mod 8 with no strobe. Code 2 changes nothing.
- R10: A read while a poll is armed disarms it. If `poll_valid` is high, `rdata` becomes 0x80 OR `poll_line` and `ack` pulses with `ack_line` = `poll_line`. Otherwise `rdata` becomes 0 and there is no ack.
- R11: A read with no poll armed loads `rdata` one cycle later with `mask` at address 1, and at address 0 with `isr` or `irr` as the read select picks. `rdata` holds between reads.
- R12: A `trig_wr` pulse loads `trig_mode` with `wdata` AND `TRIG_WMASK`. Only reset clears it; a setup start word does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the two-location port |
| rd_en | input | 1 | Read strobe for the two-location port |
| addr | input | 1 | Location select |
| wdata | input | 8 | Write data, shared with the trigger port |
| trig_wr | input | 1 | Write strobe for the trigger-mode port |
| irr | input | 8 | Request register from the resolver |
| isr | input | 8 | In-service register from the resolver |
| poll_valid | input | 1 | Resolver has a winning line |
| poll_line | input | 3 | Winning line number |
| rdata | output | 8 | Registered read data |
| mask | output | 8 | Line mask to the resolver |
| vec_base | output | 5 | Vector base, upper five bits |
| base | output | 3 | Lowest-priority-rank origin: line with top priority |
| single_mode | output | 1 | Single controller configuration |
| auto_eoi | output | 1 | Automatic end of interrupt |
| nested_mode | output | 1 | Special nested mode |
| rot_on_aeoi | output | 1 | Rotate priority on automatic end of interrupt |
| special_mask | output | 1 | Special mask mode |
| trig_mode | output | 8 | Per-line level (1) or edge (0) select |
| init_clr | output | 1 | One-cycle clear to the resolver at setup start |
| isr_clr | output | 8 | One-cycle in-service clear, at most one bit |
| ack | output | 1 | One-cycle acknowledge of a polled line |
| ack_line | output | 3 | Line being acknowledged |

## Verification
The assertions check, on every cycle, the relations that hold between neighbouring cycles:
- a setup start word always leaves mask, base and the clear pulse in the expected state;
- the in-service clear never has more than one bit set;
- an acknowledge always comes with matching poll read data;
- read data, mask and trigger bits hold when their strobes are idle;
- trigger bits never leave the writable mask.

Only the bench scenarios can show the rest. These are the word counts of the four setup walks, the choice of in-service line for every pattern and base in the end-of-interrupt sweep, the base updates of the rotating commands and the full option-word decode followed by poll and register reads.

// File: rtl/pic_cmd_seq.sv
module pic_cmd_seq #(
  parameter logic [7:0] TRIG_WMASK = 8'hF8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  input  logic       trig_wr,
  input  logic [7:0] irr,
  input  logic [7:0] isr,
  input  logic       poll_valid,
  input  logic [2:0] poll_line,
  output logic [7:0] rdata,
  output logic [7:0] mask,
  output logic [4:0] vec_base,
  output logic [2:0] base,
  output logic       single_mode,
  output logic       auto_eoi,
  output logic       nested_mode,
  output logic       rot_on_aeoi,
  output logic       special_mask,
  output logic [7:0] trig_mode,
  output logic       init_clr,
  output logic [7:0] isr_clr,
  output logic       ack,
  output logic [2:0] ack_line
);

  typedef enum logic [1:0] {S_RUN, S_VEC, S_CASC, S_MODE} st_t;
  st_t  st;
  logic need_mode, poll_q, rsel;

  wire       cmd_w = wr_en && !addr;
  wire       dat_w = wr_en && addr;
  wire       start = cmd_w && wdata[4];
  wire       optw  = cmd_w && !wdata[4] && wdata[3];
  wire       ordw  = cmd_w && !wdata[4] && !wdata[3];
  wire [2:0] code  = wdata[7:5];
  wire [2:0] lin   = wdata[2:0];

  logic       top_hit;
  logic [2:0] top_line;
  logic [2:0] idx;

  always_comb begin
    top_hit  = 1'b0;
    top_line = '0;
    idx      = '0;
    for (int k = 7; k >= 0; k--) begin
      idx = base + k[2:0];
      if (isr[idx]) begin
        top_hit  = 1'b1;
        top_line = idx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_RUN;
      need_mode <= 1'b0;
      poll_q <= 1'b0;
      rsel <= 1'b0;
      rdata <= '0;
      mask <= '0;
      vec_base <= '0;
      base <= '0;
      single_mode <= 1'b0;
      auto_eoi <= 1'b0;
      nested_mode <= 1'b0;
      rot_on_aeoi <= 1'b0;
      special_mask <= 1'b0;
      trig_mode <= '0;
      init_clr <= 1'b0;
      isr_clr <= '0;
      ack <= 1'b0;
      ack_line <= '0;
    end else begin
      init_clr <= 1'b0;
      isr_clr  <= '0;
      ack      <= 1'b0;

      if (trig_wr) trig_mode <= wdata & TRIG_WMASK;

      if (start) begin
        mask <= '0;
        vec_base <= '0;
        base <= '0;
        auto_eoi <= 1'b0;
        nested_mode <= 1'b0;
        rot_on_aeoi <= 1'b0;
        special_mask <= 1'b0;
        rsel <= 1'b0;
        poll_q <= 1'b0;
        need_mode <= wdata[0];
        single_mode <= wdata[1];
        init_clr <= 1'b1;
        st <= S_VEC;
      end else if (optw) begin
        if (wdata[2]) poll_q <= 1'b1;
        if (wdata[1]) rsel <= wdata[0];
        if (wdata[6]) special_mask <= wdata[5];
      end else if (ordw) begin
        case (code)
          3'd0, 3'd4: rot_on_aeoi <= code[2];
          3'd1, 3'd5: if (top_hit) begin
            isr_clr <= 8'b1 << top_line;
            if (code[2]) base <= top_line + 3'd1;
          end
          3'd3: isr_clr <= 8'b1 << lin;
          3'd6: base <= lin + 3'd1;
          3'd7: begin
            isr_clr <= 8'b1 << lin;
            base <= lin + 3'd1;
          end
          default: ;
        endcase
      end

      if (dat_w) begin
        case (st)
          S_RUN:  mask <= wdata;
          S_VEC: begin
            vec_base <= wdata[7:3];
            st <= single_mode ? (need_mode ? S_MODE : S_RUN) : S_CASC;
          end
          S_CASC: st <= need_mode ? S_MODE : S_RUN;
          S_MODE: begin
            nested_mode <= wdata[4];
            auto_eoi <= wdata[1];
            st <= S_RUN;
          end
          default: st <= S_RUN;
        endcase
      end

      if (rd_en) begin
        if (poll_q) begin
          poll_q <= 1'b0;
          if (poll_valid) begin
            rdata <= {5'b10000, poll_line};
            ack <= 1'b1;
            ack_line <= poll_line;
          end else begin
            rdata <= '0;
          end
        end else begin
          rdata <= addr ? mask : (rsel ? isr : irr);
        end
      end
    end
  end

endmodule

module pic_cmd_seq_chk #(
  parameter logic [7:0] TRIG_WMASK = 8'hF8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic       addr,
  input logic [7:0] wdata,
  input logic       trig_wr,
  input logic [7:0] rdata,
  input logic [7:0] mask,
  input logic [2:0] base,
  input logic       init_clr,
  input logic [7:0] isr_clr,
  input logic       ack,
  input logic [2:0] ack_line,
  input logic [7:0] trig_mode
);

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4]) |=> (init_clr && mask == 8'h00 && base == 3'd0));

  a_r8_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr_clr));

  a_r10_ack_data: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (rdata[7:3] == 5'b10000 && rdata[2:0] == ack_line));

  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  a_r3_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask));

  a_r12_trig_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_wr |=> $stable(trig_mode));

  a_r12_trig_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_mode & ~TRIG_WMASK) == 8'h00);

endmodule

bind pic_cmd_seq pic_cmd_seq_chk #(.TRIG_WMASK(TRIG_WMASK)) u_chk (.*);

// File: tb/test_pic_cmd_seq.sv
module test_pic_cmd_seq;
  localparam logic [7:0] WM = 8'hF8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, addr = 0, trig_wr = 0, poll_valid = 0;
  logic [7:0] wdata = 0, irr = 0, isr = 0;
  logic [2:0] poll_line = 0;
  logic [7:0] rdata, mask, trig_mode, isr_clr;
  logic [4:0] vec_base;
  logic [2:0] base, ack_line;
  logic single_mode, auto_eoi, nested_mode, rot_on_aeoi, special_mask, init_clr, ack;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  pic_cmd_seq #(.TRIG_WMASK(WM)) i_pic_cmd_seq (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic a);
    rd_en = 1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 0;
  endtask

  task automatic twr(input logic [7:0] d);
    trig_wr = 1; wdata = d;
    @(posedge clk); @(negedge clk);
    trig_wr = 0;
  endtask

  function automatic logic [7:0] exp_top(input logic [7:0] p, input logic [2:0] b);
    for (int k = 0; k < 8; k++)
      if (p[(b + k) % 8]) return 8'(1 << ((b + k) % 8));
    return 8'h00;
  endfunction

  function automatic logic [2:0] oh2n(input logic [7:0] o);
    for (int k = 0; k < 8; k++) if (o[k]) return 3'(k);
    return 3'd0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] eb;
    logic [7:0] e;
    logic ep, es, er;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk({rdata, mask, trig_mode, isr_clr} == 0 && vec_base == 0 && base == 0, "R1 regs", mask, 0);
    chk({single_mode, auto_eoi, nested_mode, rot_on_aeoi, special_mask, init_clr, ack} == 0,
        "R1 flags", {single_mode, auto_eoi, nested_mode, rot_on_aeoi, special_mask}, 0);
    wr(1, 8'h3C);
    chk(mask == 8'h3C, "R1 run state loads mask", mask, 8'h3C);

    // R12 trigger port
    twr(8'hFF); chk(trig_mode == WM, "R12 writable bits", trig_mode, WM);
    twr(8'h0F); chk(trig_mode == (8'h0F & WM), "R12 and mask", trig_mode, 8'h0F & WM);
    twr(8'hA8);

    // R2..R5 setup walks
    for (int c = 0; c < 4; c++) begin
      logic [7:0] v, md;
      wr(0, 8'hE4);
      wr(1, 8'hFF);
      wr(0, 8'(8'h10 | c));
      chk(init_clr && mask == 0 && base == 0 && single_mode == c[1], "R2 start word", {init_clr, single_mode, base}, {1'b1, c[1], 3'd0});
      chk(trig_mode == 8'hA8, "R12 start keeps trigger", trig_mode, 8'hA8);
      @(negedge clk);
      chk(!init_clr, "R2 pulse width", init_clr, 0);
      v = 8'(8'h47 + c * 8'h28);
      wr(1, v);
      chk(vec_base == v[7:3] && mask == 0, "R4 vector base", vec_base, v[7:3]);
      if (!c[1]) begin
        wr(1, 8'h04);
        chk(mask == 0, "R3 cascade word skipped", mask, 0);
      end
      if (c[0]) begin
        md = c[1] ? 8'h10 : 8'h02;
        wr(1, md);
        chk(mask == 0 && nested_mode == md[4] && auto_eoi == md[1], "R5 mode word",
            {nested_mode, auto_eoi}, {md[4], md[1]});
      end
      wr(1, 8'(8'h5A + c));
      chk(mask == 8'(8'h5A + c), "R3 mask after walk", mask, 8'h5A + c);
      rd(1);
      chk(rdata == 8'(8'h5A + c), "R11 read mask", rdata, 8'h5A + c);
    end

    // R8 non-specific end of interrupt, full sweep
    for (int b = 0; b < 8; b++) begin
      wr(0, 8'(8'hC0 | ((b + 7) % 8)));
      chk(base == 3'(b), "R9 code 6 base", base, b);
      for (int p = 0; p < 256; p++) begin
        isr = 8'(p);
        wr(0, 8'h20);
        e = exp_top(8'(p), 3'(b));
        chk(isr_clr == e && base == 3'(b), "R8 code 1", isr_clr, e);
      end
    end
    // R8 rotating variant
    for (int b = 0; b < 8; b++) begin
      for (int p = 0; p < 256; p += 17) begin
        wr(0, 8'(8'hC0 | ((b + 7) % 8)));
        isr = 8'(p);
        wr(0, 8'hA0);
        e = exp_top(8'(p), 3'(b));
        eb = (e == 0) ? 3'(b) : oh2n(e) + 3'd1;
        chk(isr_clr == e && base == eb, "R8 code 5", {isr_clr, base}, {e, eb});
      end
    end

    // R9 specific forms
    isr = 8'h00;
    for (int l = 0; l < 8; l++) begin
      wr(0, 8'hC3);
      wr(0, 8'(8'h60 | l));
      chk(isr_clr == 8'(1 << l) && base == 3'd4, "R9 code 3", {isr_clr, base}, {8'(1 << l), 3'd4});
      wr(0, 8'(8'hE0 | l));
      chk(isr_clr == 8'(1 << l) && base == 3'(l + 1), "R9 code 7", {isr_clr, base}, {8'(1 << l), 3'(l + 1)});
      wr(0, 8'(8'hC0 | l));
      chk(isr_clr == 0 && base == 3'(l + 1), "R9 code 6", {isr_clr, base}, {8'h0, 3'(l + 1)});
    end

    // R7 rotate flag, R9 code 2 no effect
    wr(0, 8'h84); chk(rot_on_aeoi, "R7 code 4", rot_on_aeoi, 1);
    isr = 8'hFF; wr(0, 8'hC1);
    wr(0, 8'h45);
    chk(isr_clr == 0 && base == 3'd2 && rot_on_aeoi, "R9 code 2", {isr_clr, base}, {8'h0, 3'd2});
    wr(0, 8'h00); chk(!rot_on_aeoi, "R7 code 0", rot_on_aeoi, 0);

    // R6 option word sweep with R10/R11 reads
    isr = 8'h3C; irr = 8'hC3;
    es = 0; er = 0;
    for (int n = 0; n < 32; n++) begin
      logic [7:0] w;
      w = {1'b0, n[4], n[3], 2'b01, n[2:0]};
      wr(0, w);
      if (n[4]) es = n[3];
      if (n[1]) er = n[0];
      ep = n[2];
      chk(special_mask == es, "R6 special mask", special_mask, es);
      poll_valid = n[3] ^ n[0];
      poll_line = 3'(n * 3);
      rd(0);
      if (ep) begin
        e = poll_valid ? {5'b10000, poll_line} : 8'h00;
        chk(rdata == e && ack == poll_valid && (!ack || ack_line == poll_line), "R10 poll read",
            {ack, rdata}, {poll_valid, e});
      end else begin
        e = er ? isr : irr;
        chk(rdata == e && !ack, "R11 select read", rdata, e);
      end
      rd(0);
      e = er ? isr : irr;
      chk(rdata == e && !ack, "R10 poll disarmed", rdata, e);
    end

    // R12 reset clears trigger
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    chk(trig_mode == 0 && mask == 0, "R12 reset clears trigger", trig_mode, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule